// File: doc/BRIEF.md
# Base Integer Instruction Decoder with Immediate Generator

This block is pure combinational logic. It accepts one 32-bit instruction word from the base integer instruction set and breaks it into the control fields that the rest of a pipeline needs. The outputs are:

- an operation class code
- the three-bit minor function field
- the alternate-operation bit that separates add from subtract
- the three register indices
- a 32-bit immediate, already sign-extended and built according to the instruction's format

It also raises an illegal flag for two kinds of word: words whose two lowest bits show a 16-bit or otherwise foreign encoding, and words whose major opcode is not in the supported set.

A decode stage places it between the fetch register and the execute stage. The register indices go directly to the register file read ports. The class code and minor function select the ALU or branch operation. The immediate is used either as an operand or as a byte offset for branches and jumps.

Top module: `rv32i_inst_decoder`

## Requirements
- R1: When inst_i[1:0] is not 2'b11, illegal_o is 1, class_o is 15 and imm_o is 0. This holds whatever the other bits are.
- R2: When inst_i[1:0] is 2'b11, class_o is set from inst_i[6:2] as follows:
  - 01101 gives 0 (LUI)
  - 00101 gives 1 (AUIPC)
  - 11011 gives 2 (JAL)
  - 11001 gives 3 (JALR)
  - 11000 gives 4 (BRANCH)
  - 00000 gives 5 (LOAD)
  - 01000 gives 6 (STORE)
  - 00100 gives 7 (OP-IMM)
  - 01100 gives 8 (OP)
  - 00011 gives 9 (MISC-MEM)
  - 11100 gives 10 (SYSTEM)
  - every other value gives 15 with illegal_o = 1.
  illegal_o is 0 for the eleven listed values.
- R3: funct3_o always equals inst_i[14:12], and alt_o always equals inst_i[30].
- R4: rd_o always equals inst_i[11:7], rs1_o always equals inst_i[19:15], and rs2_o always equals inst_i[24:20].
- R5: For classes 3, 5, 7, 9 and 10, imm_o is inst_i[31:20] sign-extended from inst_i[31].
- R6: For class 6, imm_o is {inst_i[31:25], inst_i[11:7]} sign-extended from inst_i[31].
- R7: For class 4, imm_o is {inst_i[31], inst_i[7], inst_i[30:25], inst_i[11:8], 0} sign-extended from inst_i[31]. As an example, 0x24F05A63 decodes as class 4, funct3 3'b101, rs1 0, rs2 15 and imm 0x254.
- R8: For classes 0 and 1, imm_o is {inst_i[31:12], 12'b0}.
- R9: For class 2, imm_o is {inst_i[31], inst_i[19:12], inst_i[20], inst_i[30:21], 0} sign-extended from inst_i[31].
- R10: For class 8, and for every illegal word, imm_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word to decode |
| class_o | output | 4 | Operation class code (15 when not recognised) |
| funct3_o | output | 3 | Minor function field |
| alt_o | output | 1 | Alternate-operation select bit |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| imm_o | output | 32 | Sign-extended immediate for the decoded format |
| illegal_o | output | 1 | Illegal or unsupported encoding |

## Verification
Two checks act on the same word at the same time. The field extractor always reports the register indices and the minor function. The legality check can still force the class to "none" and the immediate to zero.

To provoke this, the bench sweeps all 128 values of the low seven bits under many pseudo-random upper-bit patterns, with both sign values included. Valid major opcodes therefore also appear with corrupted low bits.

For each word, the bench computes the expected immediate with integer arithmetic from weighted bit groups. It also checks that the register fields stay put while the illegal flag is set.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
    localparam int ILEN    = 32;
    localparam int REG_W   = 5;
    localparam int F3_W    = 3;
    localparam int MAJ_W   = 5;
    localparam int CLS_W   = 4;
    localparam int N_FMT   = 7;

    typedef enum logic [CLS_W-1:0] {
        CLS_LUI    = 4'd0,
        CLS_AUIPC  = 4'd1,
        CLS_JAL    = 4'd2,
        CLS_JALR   = 4'd3,
        CLS_BRANCH = 4'd4,
        CLS_LOAD   = 4'd5,
        CLS_STORE  = 4'd6,
        CLS_OPIMM  = 4'd7,
        CLS_OP     = 4'd8,
        CLS_FENCE  = 4'd9,
        CLS_SYSTEM = 4'd10,
        CLS_NONE   = 4'd15
    } op_class_e;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5,
        FMT_R    = 3'd6
    } imm_fmt_e;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [F3_W-1:0]  funct3;
        logic             alt;
    } inst_fields_t;

    function automatic imm_fmt_e fmt_of(input op_class_e c);
        case (c)
            CLS_LUI, CLS_AUIPC:                           return FMT_U;
            CLS_JAL:                                      return FMT_J;
            CLS_JALR, CLS_LOAD, CLS_OPIMM,
            CLS_FENCE, CLS_SYSTEM:                        return FMT_I;
            CLS_BRANCH:                                   return FMT_B;
            CLS_STORE:                                    return FMT_S;
            CLS_OP:                                       return FMT_R;
            default:                                      return FMT_NONE;
        endcase
    endfunction

    function automatic logic [ILEN-1:0] build_imm(input imm_fmt_e f,
                                                  input logic [ILEN-1:0] w);
        logic [ILEN-1:0] s;
        s = {ILEN{w[ILEN-1]}};
        case (f)
            FMT_I: return {s[ILEN-1:12], w[31:20]};
            FMT_S: return {s[ILEN-1:12], w[31:25], w[11:7]};
            FMT_B: return {s[ILEN-1:13], w[31], w[7], w[30:25], w[11:8], 1'b0};
            FMT_U: return {w[31:12], 12'b0};
            FMT_J: return {s[ILEN-1:21], w[31], w[19:12], w[20], w[30:21], 1'b0};
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/rvdec_fields.sv
module rvdec_fields
    import rvdec_pkg::*;
(
    input  logic [ILEN-1:0] inst_i,
    output inst_fields_t    fields_o
);
    always_comb begin
        fields_o.rd     = inst_i[11:7];
        fields_o.rs1    = inst_i[19:15];
        fields_o.rs2    = inst_i[24:20];
        fields_o.funct3 = inst_i[14:12];
        fields_o.alt    = inst_i[30];
    end
endmodule

// File: rtl/rvdec_class.sv
module rvdec_class
    import rvdec_pkg::*;
(
    input  logic [ILEN-1:0] inst_i,
    output op_class_e       class_o,
    output imm_fmt_e        fmt_o,
    output logic            illegal_o
);
    logic      wide_ok;
    op_class_e major_cls;

    always_comb begin
        wide_ok = (inst_i[1:0] == 2'b11);
        case (inst_i[6:2])
            5'b01101: major_cls = CLS_LUI;
            5'b00101: major_cls = CLS_AUIPC;
            5'b11011: major_cls = CLS_JAL;
            5'b11001: major_cls = CLS_JALR;
            5'b11000: major_cls = CLS_BRANCH;
            5'b00000: major_cls = CLS_LOAD;
            5'b01000: major_cls = CLS_STORE;
            5'b00100: major_cls = CLS_OPIMM;
            5'b01100: major_cls = CLS_OP;
            5'b00011: major_cls = CLS_FENCE;
            5'b11100: major_cls = CLS_SYSTEM;
            default:  major_cls = CLS_NONE;
        endcase
        class_o   = wide_ok ? major_cls : CLS_NONE;
        illegal_o = (class_o == CLS_NONE);
        fmt_o     = fmt_of(class_o);
    end

    always_comb begin
        if (inst_i[1:0] != 2'b11)
            assert_short_enc_R1: assert (illegal_o && fmt_o == FMT_NONE)
                else $error("short encoding not flagged");
        if (!illegal_o)
            assert_legal_has_fmt_R2: assert (fmt_o != FMT_NONE)
                else $error("legal class without format");
    end
endmodule

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
    import rvdec_pkg::*;
(
    input  logic [ILEN-1:0] inst_i,
    input  imm_fmt_e        fmt_i,
    output logic [ILEN-1:0] imm_o
);
    logic [ILEN-1:0] cand [N_FMT];

    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        assign cand[g] = build_imm(imm_fmt_e'(g), inst_i);
    end

    always_comb begin
        imm_o = '0;
        for (int k = 0; k < N_FMT; k++)
            if (fmt_i == imm_fmt_e'(k)) imm_o = cand[k];
    end

    always_comb begin
        if (fmt_i == FMT_I || fmt_i == FMT_S || fmt_i == FMT_B || fmt_i == FMT_J)
            assert_sign_bit_R5: assert (imm_o[ILEN-1] == inst_i[31] && imm_o[11] == (fmt_i == FMT_B ? inst_i[7] : (fmt_i == FMT_J ? inst_i[20] : inst_i[31])))
                else $error("immediate sign handling wrong");
        if (fmt_i == FMT_B || fmt_i == FMT_J)
            assert_even_offset_R7: assert (imm_o[0] == 1'b0)
                else $error("branch/jump offset odd");
        if (fmt_i == FMT_U)
            assert_upper_low_zero_R8: assert (imm_o[11:0] == 12'b0)
                else $error("upper immediate low bits set");
    end
endmodule

// File: rtl/rv32i_inst_decoder.sv
module rv32i_inst_decoder
    import rvdec_pkg::*;
(
    input  logic [31:0] inst_i,
    output logic [3:0]  class_o,
    output logic [2:0]  funct3_o,
    output logic        alt_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [4:0]  rd_o,
    output logic [31:0] imm_o,
    output logic        illegal_o
);
    inst_fields_t fld;
    op_class_e    cls;
    imm_fmt_e     fmt;
    logic         bad;
    logic [ILEN-1:0] imm;

    rvdec_fields u_fields (
        .inst_i   (inst_i),
        .fields_o (fld)
    );

    rvdec_class u_class (
        .inst_i    (inst_i),
        .class_o   (cls),
        .fmt_o     (fmt),
        .illegal_o (bad)
    );

    rvdec_immgen u_imm (
        .inst_i (inst_i),
        .fmt_i  (fmt),
        .imm_o  (imm)
    );

    assign class_o   = cls;
    assign funct3_o  = fld.funct3;
    assign alt_o     = fld.alt;
    assign rs1_o     = fld.rs1;
    assign rs2_o     = fld.rs2;
    assign rd_o      = fld.rd;
    assign imm_o     = imm;
    assign illegal_o = bad;

    always_comb begin
        if (illegal_o || class_o == 4'd8)
            assert_zero_imm_R10: assert (imm_o == 32'd0)
                else $error("immediate not cleared");
    end
endmodule

// File: tb/rv32i_inst_decoder_tb_top.sv
module rv32i_inst_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] inst;
    logic [3:0]  cls;
    logic [2:0]  f3;
    logic        alt;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;
    logic        ill;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv32i_inst_decoder dut_i (
        .inst_i(inst), .class_o(cls), .funct3_o(f3), .alt_o(alt),
        .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd), .imm_o(imm), .illegal_o(ill)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input logic [31:0] w);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst=%08h actual=%08h expected=%08h", req, w, act, exp);
        end
    endtask

    function automatic int exp_class(input logic [31:0] w);
        if (w[1:0] != 2'b11) return 15;
        case (w[6:2])
            5'b01101: return 0;  5'b00101: return 1;  5'b11011: return 2;
            5'b11001: return 3;  5'b11000: return 4;  5'b00000: return 5;
            5'b01000: return 6;  5'b00100: return 7;  5'b01100: return 8;
            5'b00011: return 9;  5'b11100: return 10;
            default:  return 15;
        endcase
    endfunction

    function automatic logic [31:0] exp_imm(input logic [31:0] w, input int c);
        int v;
        int neg;
        neg = w[31] ? 1 : 0;
        case (c)
            3, 5, 7, 9, 10: v = -neg * 2048 + int'(w[30:20]);
            6:              v = -neg * 2048 + int'(w[30:25]) * 32 + int'(w[11:7]);
            4:              v = -neg * 4096 + int'(w[7]) * 2048 + int'(w[30:25]) * 32
                                + int'(w[11:8]) * 2;
            0, 1:           v = int'(w[31:12] * 4096);
            2:              v = -neg * 1048576 + int'(w[19:12]) * 4096 + int'(w[20]) * 2048
                                + int'(w[30:21]) * 2;
            default:        v = 0;
        endcase
        return 32'(v);
    endfunction

    task automatic apply(input logic [31:0] w);
        int c;
        string rq;
        @(posedge clk);
        inst = w;
        @(negedge clk);
        c = exp_class(w);
        rq = (w[1:0] != 2'b11) ? "R1" : "R2";
        chk(rq, 32'(cls), 32'(c), w);
        chk(rq, 32'(ill), (c == 15) ? 32'd1 : 32'd0, w);
        chk("R3", {28'd0, alt, f3}, {28'd0, w[30], w[14:12]}, w);
        chk("R4", {17'd0, rd, rs1, rs2}, {17'd0, w[11:7], w[19:15], w[24:20]}, w);
        case (c)
            3, 5, 7, 9, 10: chk("R5", imm, exp_imm(w, c), w);
            6:              chk("R6", imm, exp_imm(w, c), w);
            4:              chk("R7", imm, exp_imm(w, c), w);
            0, 1:           chk("R8", imm, exp_imm(w, c), w);
            2:              chk("R9", imm, exp_imm(w, c), w);
            default:        chk("R10", imm, 32'd0, w);
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        inst = 32'd0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset-state word: all zero, short encoding (R1)
        chk("R1", 32'(ill), 32'd1, inst);
        chk("R1", 32'(cls), 32'd15, inst);
        chk("R1", imm, 32'd0, inst);

        // worked branch example (R7)
        apply(32'h24F05A63);
        chk("R7", 32'(cls), 32'd4, inst);
        chk("R7", 32'(f3), 32'd5, inst);
        chk("R7", {27'd0, rs1}, 32'd0, inst);
        chk("R7", {27'd0, rs2}, 32'd15, inst);
        chk("R7", imm, 32'h254, inst);

        // negative extremes for each format
        apply(32'hFFFFFFFF);
        apply(32'h80000063);
        apply(32'h8000006F);
        apply(32'hFFFFF037);
        apply(32'h40000033);

        // sweep of every low-seven-bit value under varied upper bits
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 64; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            for (int op = 0; op < 128; op++)
                apply({k[0], lfsr[30:7], 7'(op)});
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule